// File: doc/BRIEF.md
# Indirect Addressing Pointer Unit

This block resolves the operand addresses of a small 8-bit core that reaches a 4096-byte data RAM through three 12-bit pointer registers. The core presents a 12-bit operand address with a read or write strobe. The unit works out where that access really lands, drives the RAM port, and returns read data to the core. Each pointer owns a group of eight consecutive addresses starting at `BASE + 8*n`, where n is the pointer number and `BASE` defaults to 0xFE0. Slots 0 to 4 of a group are virtual aliases with no storage behind them. Slot 5 is the pointer's low byte, slot 6 holds its upper four bits, and slot 7 is ordinary RAM.

An access to an alias uses the pointer, or the pointer adjusted by that alias's mode, as the effective address. The slot number selects the mode:
- slot 0: plain access;
- slot 1: use the pointer, then decrement it;
- slot 2: use the pointer, then increment it;
- slot 3: increment the pointer first and use the new value;
- slot 4: add the working register, read as a signed byte, and leave the pointer unchanged.

Any effective address that falls back onto an alias, or onto a pointer byte, is handled inside the unit and never reaches the RAM. A separate load port writes all 12 bits of one pointer in a single cycle.

Top module: `ptrUnit`

## Requirements
- R1: After reset all pointers read as zero through their slot 5 and slot 6 addresses.
- R2: An access through slot 0 of pointer n uses the pointer value as the effective address and leaves the pointer unchanged.
- R3: An access through slot 1 uses the current pointer value, and the pointer then holds that value minus one, modulo 4096, after the clock edge of the access.
- R4: An access through slot 2 uses the current pointer value, and the pointer then holds that value plus one, modulo 4096. A carry out of the low byte reaches the upper bits.
- R5: An access through slot 3 uses the pointer value plus one, modulo 4096, as the effective address. The pointer holds that same value afterwards.
- R6: An access through slot 4 uses the pointer plus the sign-extended working register (-128 to +127), modulo 4096, as the effective address. The pointer is not changed.
- R7: A read whose effective address is any alias slot (0 to 4 of any group) returns 0x00, raises `zeroRd` for that cycle and issues no RAM read. Any pointer step of the access still takes place.
- R8: A write whose effective address is any alias slot issues no RAM write and changes no pointer.
- R9: An indirect write whose effective address is a slot 5 or slot 6 address stores the data into that pointer byte. The accessing pointer's increment or decrement is skipped, and the RAM is not written.
- R10: A slot 6 read returns the pointer's upper four bits in bits 3:0 and zero in bits 7:4. A slot 6 write keeps only data bits 3:0. A slot 5 write replaces the low eight bits.
- R11: `ldEn` writes `ldVal` into pointer `ldSel` in one cycle. It takes priority over any access that updates the same pointer in that cycle.
- R12: An address outside slots 0 to 6 of every group goes straight to the RAM. `ramAddr` equals `opAddr`, `ramRe` or `ramWe` follows the strobe, `rdData` equals `ramRdata`, and `zeroRd` stays low. With no strobe, neither RAM strobe nor `zeroRd` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; pointer updates commit on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wreg | input | 8 | Working register, signed offset for slot 4 |
| opAddr | input | 12 | Operand address from the core |
| opRd | input | 1 | Read strobe; ignored when opWr is high |
| opWr | input | 1 | Write strobe |
| opWdata | input | 8 | Write data from the core |
| rdData | output | 8 | Read data to the core, zero when no read |
| zeroRd | output | 1 | Read landed on an alias and returned zero |
| ldEn | input | 1 | Full 12-bit pointer load |
| ldSel | input | 2 | Pointer selected by the load |
| ldVal | input | 12 | Value loaded |
| ramAddr | output | 12 | RAM address |
| ramRe | output | 1 | RAM read enable |
| ramWe | output | 1 | RAM write enable |
| ramWdata | output | 8 | RAM write data |
| ramRdata | input | 8 | RAM read data, combinational from ramAddr |

## Verification
The hardest cases to reach from the ports are effective addresses that fold back into the pointer region. These include a pre-increment that steps onto an alias, an indexed sum that lands on another pointer's high byte, and a wrap past 0xFFF. The bench reaches them by loading pointers just below and inside the region with the full-width load. It then sweeps every pointer, every slot and a set of working-register offsets. For each access it computes the landing slot arithmetically and predicts the read data, the RAM strobes and all three pointer values.

// File: rtl/ptrPkg.sv
package ptrPkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 8;
  localparam int SEL_W  = 2;
  localparam int SLOT_W = 3;
  localparam int GROUP  = 1 << SLOT_W;

  localparam logic [SLOT_W-1:0] SLOT_LO = 3'd5;
  localparam logic [SLOT_W-1:0] SLOT_HI = 3'd6;

  typedef enum logic [SLOT_W-1:0] {
    MODE_PLAIN   = 3'd0,
    MODE_POSTDEC = 3'd1,
    MODE_POSTINC = 3'd2,
    MODE_PREINC  = 3'd3,
    MODE_INDEX   = 3'd4
  } modeT;

  typedef struct packed {
    logic              inRegion;
    logic [SEL_W-1:0]  sel;
    logic [SLOT_W-1:0] slot;
  } addrClassT;

  typedef struct packed {
    logic             rd;
    logic             wr;
    logic             indirect;
    logic [SEL_W-1:0] sel;
    modeT             mode;
  } strobeT;

  function automatic addrClassT classify(input logic [ADDR_W-1:0] addr,
                                         input logic [ADDR_W-1:0] base,
                                         input int numPtr);
    addrClassT c;
    logic [ADDR_W-1:0] off;
    off = addr - base;
    c.inRegion = (int'(off) < numPtr * GROUP);
    c.sel  = c.inRegion ? off[SLOT_W +: SEL_W] : '0;
    c.slot = c.inRegion ? off[SLOT_W-1:0] : '0;
    return c;
  endfunction

  function automatic logic isAlias(input addrClassT c);
    return c.inRegion && (c.slot <= SLOT_W'(MODE_INDEX));
  endfunction

  function automatic logic isPtrByte(input addrClassT c);
    return c.inRegion && ((c.slot == SLOT_LO) || (c.slot == SLOT_HI));
  endfunction
endpackage

// File: rtl/ptrCtrl.sv
module ptrCtrl
  import ptrPkg::*;
#(
  parameter logic [ADDR_W-1:0] BASE = 12'hFE0,
  parameter int NUM_PTR = 3
) (
  input  logic [ADDR_W-1:0] opAddr,
  input  logic              opRd,
  input  logic              opWr,
  output strobeT            stb
);
  addrClassT opClass;
  logic      anyAccess;

  always_comb begin
    opClass   = classify(opAddr, BASE, NUM_PTR);
    anyAccess = opRd | opWr;
    stb.wr       = opWr;
    stb.rd       = opRd & ~opWr;
    stb.indirect = anyAccess & isAlias(opClass);
    stb.sel      = opClass.sel;
    stb.mode     = isAlias(opClass) ? modeT'(opClass.slot) : MODE_PLAIN;
  end
endmodule

// File: rtl/ptrData.sv
module ptrData
  import ptrPkg::*;
#(
  parameter logic [ADDR_W-1:0] BASE = 12'hFE0,
  parameter int NUM_PTR = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  logic [DATA_W-1:0] wreg,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [DATA_W-1:0] opWdata,
  input  logic              ldEn,
  input  logic [SEL_W-1:0]  ldSel,
  input  logic [ADDR_W-1:0] ldVal,
  input  logic [DATA_W-1:0] ramRdata,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramRe,
  output logic              ramWe,
  output logic [DATA_W-1:0] ramWdata,
  output logic [DATA_W-1:0] rdData,
  output logic              zeroRd
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] ptrQ [NUM_PTR];
  logic [ADDR_W-1:0] curPtr, effAddr, tgtAddr, stepVal, offsetExt;
  logic [DATA_W-1:0] byteVal;
  addrClassT         tgtClass;
  logic              tgtAlias, tgtByte, stepMode, stepEn, byteWr;

  // pointer selected by the operand, and its candidate addresses
  always_comb begin
    curPtr = '0;
    for (int i = 0; i < NUM_PTR; i++)
      if (stb.sel == SEL_W'(i)) curPtr = ptrQ[i];
    offsetExt = {{HI_W{wreg[DATA_W-1]}}, wreg};
    unique case (stb.mode)
      MODE_PREINC: effAddr = curPtr + 1'b1;
      MODE_INDEX:  effAddr = curPtr + offsetExt;
      default:     effAddr = curPtr;
    endcase
    stepVal  = (stb.mode == MODE_POSTDEC) ? curPtr - 1'b1 : curPtr + 1'b1;
    stepMode = (stb.mode == MODE_POSTDEC) || (stb.mode == MODE_POSTINC) ||
               (stb.mode == MODE_PREINC);
  end

  // final target and what lives there
  always_comb begin
    tgtAddr  = stb.indirect ? effAddr : opAddr;
    tgtClass = classify(tgtAddr, BASE, NUM_PTR);
    tgtAlias = isAlias(tgtClass);
    tgtByte  = isPtrByte(tgtClass);
    byteVal  = '0;
    for (int i = 0; i < NUM_PTR; i++)
      if (tgtClass.sel == SEL_W'(i))
        byteVal = (tgtClass.slot == SLOT_HI) ?
                  {{(DATA_W-HI_W){1'b0}}, ptrQ[i][ADDR_W-1:DATA_W]} :
                  ptrQ[i][DATA_W-1:0];
  end

  always_comb begin
    ramAddr  = tgtAddr;
    ramWdata = opWdata;
    ramRe    = stb.rd & ~tgtAlias & ~tgtByte;
    ramWe    = stb.wr & ~tgtAlias & ~tgtByte;
    zeroRd   = stb.rd & tgtAlias;
    if (!stb.rd || tgtAlias) rdData = '0;
    else if (tgtByte)        rdData = byteVal;
    else                     rdData = ramRdata;
    byteWr = stb.wr & tgtByte;
    stepEn = stb.indirect & stepMode & ~(stb.wr & (tgtAlias | tgtByte));
  end

  // pointer registers: full load, then byte write, then mode step
  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_PTR; i++) begin
      if (!rstN)
        ptrQ[i] <= '0;
      else if (ldEn && ldSel == SEL_W'(i))
        ptrQ[i] <= ldVal;
      else if (byteWr && tgtClass.sel == SEL_W'(i)) begin
        if (tgtClass.slot == SLOT_HI)
          ptrQ[i][ADDR_W-1:DATA_W] <= opWdata[HI_W-1:0];
        else
          ptrQ[i][DATA_W-1:0] <= opWdata;
      end
      else if (stepEn && stb.sel == SEL_W'(i))
        ptrQ[i] <= stepVal;
    end
  end
endmodule

// File: rtl/ptrUnit.sv
module ptrUnit
  import ptrPkg::*;
#(
  parameter logic [ADDR_W-1:0] BASE = 12'hFE0,
  parameter int NUM_PTR = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] wreg,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic              opRd,
  input  logic              opWr,
  input  logic [DATA_W-1:0] opWdata,
  output logic [DATA_W-1:0] rdData,
  output logic              zeroRd,
  input  logic              ldEn,
  input  logic [SEL_W-1:0]  ldSel,
  input  logic [ADDR_W-1:0] ldVal,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramRe,
  output logic              ramWe,
  output logic [DATA_W-1:0] ramWdata,
  input  logic [DATA_W-1:0] ramRdata
);
  strobeT stb;

  ptrCtrl #(.BASE(BASE), .NUM_PTR(NUM_PTR)) u_ctrl (
    .opAddr(opAddr), .opRd(opRd), .opWr(opWr), .stb(stb)
  );

  ptrData #(.BASE(BASE), .NUM_PTR(NUM_PTR)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .wreg(wreg), .opAddr(opAddr),
    .opWdata(opWdata), .ldEn(ldEn), .ldSel(ldSel), .ldVal(ldVal),
    .ramRdata(ramRdata), .ramAddr(ramAddr), .ramRe(ramRe), .ramWe(ramWe),
    .ramWdata(ramWdata), .rdData(rdData), .zeroRd(zeroRd)
  );
endmodule

// File: rtl/ptrUnitChk.sv
module ptrUnitChk #(
  parameter logic [11:0] BASE = 12'hFE0,
  parameter int NUM_PTR = 3
) (
  input logic        clk,
  input logic        rstN,
  input logic [11:0] opAddr,
  input logic        opRd,
  input logic        opWr,
  input logic [7:0]  rdData,
  input logic        zeroRd,
  input logic [11:0] ramAddr,
  input logic        ramRe,
  input logic        ramWe,
  input logic [7:0]  ramRdata
);
  function automatic logic special(input logic [11:0] a);
    logic [11:0] off;
    off = a - BASE;
    return (int'(off) < NUM_PTR * 8) && (off[2:0] != 3'd7);
  endfunction

  function automatic logic hiSlot(input logic [11:0] a);
    logic [11:0] off;
    off = a - BASE;
    return (int'(off) < NUM_PTR * 8) && (off[2:0] == 3'd6);
  endfunction

  AST_ZERO_READ_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    zeroRd |-> (opRd && !opWr && rdData == 8'h00 && !ramRe));  // R7

  AST_NO_RAM_WRITE_SPECIAL: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> !special(ramAddr));  // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!opRd && !opWr) |-> (!ramRe && !ramWe && !zeroRd));  // R12

  AST_DIRECT_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (opRd && !opWr && !special(opAddr)) |->
      (ramRe && ramAddr == opAddr && rdData == ramRdata && !zeroRd));  // R12

  AST_HI_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (opRd && !opWr && hiSlot(opAddr)) |-> (rdData[7:4] == 4'h0));  // R10
endmodule

bind ptrUnit ptrUnitChk #(.BASE(BASE), .NUM_PTR(NUM_PTR)) u_chk (
  .clk(clk), .rstN(rstN), .opAddr(opAddr), .opRd(opRd), .opWr(opWr),
  .rdData(rdData), .zeroRd(zeroRd), .ramAddr(ramAddr), .ramRe(ramRe),
  .ramWe(ramWe), .ramRdata(ramRdata)
);

// File: tb/ptrUnit_tb.sv
module ptrUnit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 'hFE0;

  logic clk = 1'b0, rstN = 1'b0;
  logic [7:0]  wreg = '0, opWdata = '0, rdData, ramWdata, ramRdata;
  logic [11:0] opAddr = '0, ldVal = '0, ramAddr;
  logic        opRd = 1'b0, opWr = 1'b0, ldEn = 1'b0, zeroRd, ramRe, ramWe;
  logic [1:0]  ldSel = '0;
  logic [7:0]  mem [0:4095];

  ptrUnit #(.BASE(12'(BASE)), .NUM_PTR(3)) u_dut (
    .clk(clk), .rstN(rstN), .wreg(wreg), .opAddr(opAddr), .opRd(opRd),
    .opWr(opWr), .opWdata(opWdata), .rdData(rdData), .zeroRd(zeroRd),
    .ldEn(ldEn), .ldSel(ldSel), .ldVal(ldVal), .ramAddr(ramAddr),
    .ramRe(ramRe), .ramWe(ramWe), .ramWdata(ramWdata), .ramRdata(ramRdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  assign ramRdata = mem[ramAddr];
  always @(posedge clk) if (ramWe) mem[ramAddr] <= ramWdata;

  int checks = 0, fails = 0;
  int mptr[3];
  int cRd, cZ, cAddr, cRe, cWe;
  bit done = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic access(input int a, input bit rd, input bit wr, input int wd);
    @(negedge clk);
    opAddr = 12'(a); opRd = rd; opWr = wr; opWdata = 8'(wd);
    #1;
    cRd = rdData; cZ = zeroRd; cAddr = ramAddr; cRe = ramRe; cWe = ramWe;
    @(posedge clk); #1;
    opRd = 1'b0; opWr = 1'b0;
  endtask

  task automatic loadPtr(input int p, input int v);
    @(negedge clk);
    ldEn = 1'b1; ldSel = 2'(p); ldVal = 12'(v);
    @(posedge clk); #1;
    ldEn = 1'b0;
    mptr[p] = v;
  endtask

  task automatic readPtr(input int p, output int val);
    int lo, hi;
    access(BASE + 8*p + 5, 1, 0, 0); lo = cRd;
    access(BASE + 8*p + 6, 1, 0, 0); hi = cRd;
    chk("R10", "hi byte upper bits", hi >> 4, 0);
    val = ((hi & 'hF) << 8) | lo;
  endtask

  function automatic int slotOf(input int a);
    int off = (a - BASE) & 'hFFF;
    return (off < 24) ? off % 8 : 7;
  endfunction

  function automatic int ptrOf(input int a);
    return ((a - BASE) & 'hFFF) / 8;
  endfunction

  function automatic string tagOf(input int m);
    case (m)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic int effOf(input int v, input int m, input int w);
    int sw = (w >= 128) ? w - 256 : w;
    case (m)
      3: return (v + 1) & 'hFFF;
      4: return (v + sw) & 'hFFF;
      default: return v;
    endcase
  endfunction

  function automatic int stepOf(input int v, input int m);
    case (m)
      1: return (v - 1) & 'hFFF;
      2, 3: return (v + 1) & 'hFFF;
      default: return v;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int pv[6] = '{'h000, 'h0FF, 'h100, 'hFFF, 'hFDF, 'hFE5};
    int wv[5] = '{'h00, 'h7F, 'h80, 'hFF, 'h05};
    int ww[3] = '{'h05, 'h06, 'hFF};
    int got, ea, s, q, expRd, nj;
    for (int a = 0; a < 4096; a++) mem[a] <= 8'(a * 7 + 3);
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1: reset state
    for (int k = 0; k < 3; k++) begin
      readPtr(k, got); chk("R1", "pointer after reset", got, 0); mptr[k] = 0;
    end

    // R10: byte writes to slot 5/6
    access(BASE + 8 + 6, 0, 1, 'hFF);
    access(BASE + 8 + 5, 0, 1, 'h5A);
    readPtr(1, got); chk("R10", "byte-written pointer", got, 'hF5A); mptr[1] = 'hF5A;

    // R11: load beats concurrent post-increment on same pointer
    @(negedge clk);
    ldEn = 1'b1; ldSel = 2'd0; ldVal = 12'h321; opAddr = 12'(BASE + 2); opRd = 1'b1;
    @(posedge clk); #1; ldEn = 1'b0; opRd = 1'b0;
    readPtr(0, got); chk("R11", "load priority", got, 'h321); mptr[0] = 'h321;

    // R12: direct RAM traffic, including slot 7
    access('h234, 0, 1, 'h99);
    chk("R12", "direct we", cWe, 1); chk("R12", "direct addr", cAddr, 'h234);
    access('h234, 1, 0, 0);
    chk("R12", "direct read", cRd, 'h99); chk("R12", "direct zero", cZ, 0);
    access(BASE + 7, 1, 0, 0);
    chk("R12", "slot7 re", cRe, 1); chk("R12", "slot7 addr", cAddr, BASE + 7);

    // read sweep over pointers, modes, values, offsets
    for (int p = 0; p < 3; p++)
      for (int m = 0; m < 5; m++)
        for (int i = 0; i < 6; i++) begin
          nj = (m == 4) ? 5 : 1;
          for (int j = 0; j < nj; j++) begin
            loadPtr(p, pv[i]);
            wreg = 8'(wv[j]);
            ea = effOf(pv[i], m, wv[j]); s = slotOf(ea); q = ptrOf(ea);
            if (s <= 4) expRd = 0;
            else if (s == 5) expRd = mptr[q] & 'hFF;
            else if (s == 6) expRd = mptr[q] >> 8;
            else expRd = mem[ea];
            access(BASE + 8*p + m, 1, 0, 0);
            chk(s <= 4 ? "R7" : tagOf(m), "read data", cRd, expRd);
            chk("R7", "zero flag", cZ, (s <= 4) ? 1 : 0);
            if (s == 7) chk(tagOf(m), "ram addr", cAddr, ea);
            mptr[p] = stepOf(pv[i], m);
            readPtr(p, got); chk(tagOf(m), "pointer after read", got, mptr[p]);
          end
        end

    // write sweep
    for (int p = 0; p < 3; p++)
      for (int m = 0; m < 5; m++)
        for (int i = 0; i < 6; i++) begin
          nj = (m == 4) ? 3 : 1;
          for (int j = 0; j < nj; j++) begin
            loadPtr(p, pv[i]);
            wreg = 8'(ww[j]);
            ea = effOf(pv[i], m, ww[j]); s = slotOf(ea); q = ptrOf(ea);
            access(BASE + 8*p + m, 0, 1, 'h3C);
            if (s <= 4) begin
              chk("R8", "ram we on alias", cWe, 0);
            end else if (s <= 6) begin
              chk("R9", "ram we on pointer byte", cWe, 0);
              if (s == 6) mptr[q] = (mptr[q] & 'hFF) | ('hC << 8);
              else mptr[q] = (mptr[q] & 'hF00) | 'h3C;
            end else begin
              chk(tagOf(m), "ram we", cWe, 1);
              chk(tagOf(m), "ram addr", cAddr, ea);
              chk(tagOf(m), "ram data", mem[ea], 'h3C);
              mptr[p] = stepOf(pv[i], m);
            end
            for (int k = 0; k < 3; k++) begin
              readPtr(k, got);
              chk(s <= 4 ? "R8" : (s <= 6 ? "R9" : tagOf(m)), "pointer after write",
                  got, mptr[k]);
            end
          end
        end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule